// File: doc/BRIEF.md
# Cascadable three-counter watchdog timer

The block holds three counters that advance on a slow tick, qualified by a single-cycle `tick_en` strobe in the system clock domain. Two short counters (C0, C1, 16 bits by default) compare against a programmable match value. Each either wraps to zero when it reaches that value or runs on to its full range. The long counter (C2, 32 bits by default) has no match value. Its event is the rising edge of one selectable bit of its count. C1 can be chained to step only on C0 events, and C2 only on C1 events. Chaining builds periods far longer than any one counter. For example, a C0 match of 32768 and a C1 match of 16, both wrapping and chained, give one C1 event every 524288 ticks.

Each counter's event can do nothing, raise a status bit that drives the interrupt, or act as a watchdog. In watchdog mode the first event raises the status bit. A further event while that bit is still set issues a one-clock reset request. Software reaches the block through a plain single-cycle register port. A write takes effect at the clock edge where `reg_wr` is high, and reads are combinational from `reg_addr`. The port has no valid/ready handshake and never applies back-pressure. Counter configuration sits behind a two-write unlock key. The interrupt mask and the write-one-to-clear status register are always writable, so a service routine needs no key.

Register addresses: 0 lock, 1 enable, 2 C0 match, 3 C1 match, 4 mode, 5 mask, 6 status, 7 counter reset, 8/9/10 counts of C0/C1/C2.

Top module: `mcw_top`

## Requirements
- R1: After reset all three counts read 0, status reads 0, `irq` and `rst_req` are low, and the lock register (address 0) reads 0, meaning locked.
- R2: The enable, match, mode and counter-reset registers (addresses 1, 2, 3, 4, 7) accept writes only while unlocked. Writing 0xA5 and then 0x5A to address 0, as consecutive writes, unlocks the block, and address 0 then reads 1. Any other write after 0xA5 relocks the block and is itself dropped. A write of any value other than 0xA5 to address 0 while unlocked relocks the block.
- R3: In the mode register (address 4), bit 8 selects wrap-on-match for C0 and bit 9 does the same for C1. A C0/C1 event fires on the tick that brings the count to the match value. With wrap-on-match the count then becomes 0 in the same step, so the period is the match value in ticks. Without it the count continues, wrapping at 2^16.
- R4: Mode bits [20:16] select a bit of C2. A C2 event fires on the step where that bit goes from 0 to 1.
- R5: Mode bit 12 makes C1 step only on C0 events, and mode bit 13 makes C2 step only on C1 events.
- R6: Mode bits [1:0], [3:2] and [5:4] hold the actions of C0, C1 and C2 (0 = none, 1 = interrupt, 2 = watchdog). An event of a counter whose action is none leaves its status bit at 0. Actions 1 and 2 set the status bit.
- R7: In watchdog mode, an event arriving while the counter's status bit is already set makes `rst_req` high for exactly one clock.
- R8: The mask register (address 5, bits [2:0]) gates the status bits. `irq` is the OR of status AND mask. A read of address 6 returns the masked status in [2:0] and the raw status in [6:4].
- R9: Writing address 6 clears every status bit whose write-data bit is 1 and leaves the others unchanged.
- R10: Enable register bits [2:0] enable C0, C1 and C2. Counts change only on cycles with `tick_en` high and only while enabled. Disabling a counter clears its status bit.
- R11: Writing 1 to a bit of address 7 makes the matching counter read 0 after the next tick. That tick does not count up and does not produce an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Single-cycle slow tick strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register address |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Combinational read data for reg_addr |
| irq | output | 1 | OR of masked status |
| rst_req | output | 1 | One-clock watchdog reset request |

## Verification
A wrong count or a missed wrap shows directly in the count registers and in status after the same tick that caused it. A wrong period therefore appears within one period of the programmed match. A broken cascade or toggle-bit choice shows up as a status bit that rises one chained step early or late. A stale pending watchdog state shows as a `rst_req` pulse one clock after an event. That pulse appears where none is due, or is absent where one is due. A lock state machine stuck open or shut appears on the very next configuration write as a readback mismatch.

// File: rtl/mcw_pkg.sv
package mcw_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_WDOG = 2'd2,
    ACT_RSVD = 2'd3
  } act_t;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lk_t;

  localparam int A_LOCK   = 0;
  localparam int A_CTRL   = 1;
  localparam int A_MATCH0 = 2;
  localparam int A_MATCH1 = 3;
  localparam int A_MODE   = 4;
  localparam int A_MASK   = 5;
  localparam int A_STAT   = 6;
  localparam int A_CRST   = 7;
  localparam int A_CNT0   = 8;
  localparam int A_CNT1   = 9;
  localparam int A_CNT2   = 10;

  localparam logic [31:0] KEY_A = 32'h0000_00A5;
  localparam logic [31:0] KEY_B = 32'h0000_005A;

  typedef struct packed {
    logic [2:0] en;
    act_t       act0;
    act_t       act1;
    act_t       act2;
    logic       clr0;
    logic       clr1;
    logic       casc01;
    logic       casc12;
    logic [2:0] mask;
  } cfg_t;
endpackage

// File: rtl/mcw_match_ctr.sv
module mcw_match_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         adv,
  input  logic         en,
  input  logic         wrap_mode,
  input  logic [W-1:0] match,
  input  logic         zap,
  output logic [W-1:0] cnt,
  output logic         evt
);
  logic         pend;
  logic         apply_zap;
  logic         step;
  logic [W-1:0] nxt;

  assign apply_zap = tick & pend;
  assign step      = adv & en & ~apply_zap;
  assign nxt       = cnt + 1'b1;
  assign evt       = step & (nxt == match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (zap)       pend <= 1'b1;
      else if (tick) pend <= 1'b0;
      if (apply_zap)           cnt <= '0;
      else if (step) begin
        if (evt && wrap_mode)  cnt <= '0;
        else                   cnt <= nxt;
      end
    end
  end

  // R10: the count is frozen on cycles without a tick
  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R11: a pending zero request clears the count on the next tick
  p_zap_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend) |=> (cnt == '0));
endmodule

// File: rtl/mcw_toggle_ctr.sv
module mcw_toggle_ctr #(
  parameter int W   = 32,
  parameter int TBW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           adv,
  input  logic           en,
  input  logic [TBW-1:0] tbit,
  input  logic           zap,
  output logic [W-1:0]   cnt,
  output logic           evt
);
  logic         pend;
  logic         apply_zap;
  logic         step;
  logic [W-1:0] nxt;

  assign apply_zap = tick & pend;
  assign step      = adv & en & ~apply_zap;
  assign nxt       = cnt + 1'b1;
  assign evt       = step & ~cnt[tbit] & nxt[tbit];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (zap)            pend <= 1'b1;
      else if (tick)      pend <= 1'b0;
      if (apply_zap)      cnt <= '0;
      else if (step)      cnt <= nxt;
    end
  end

  // R4: after an event the selected bit of the count is set
  p_bit_set_after_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cnt[$past(tbit)]);
  // R10: the long count is frozen on cycles without a tick
  p_hold_no_tick_long_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/mcw_regs.sv
module mcw_regs
  import mcw_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int SW  = 16,
  parameter int LW  = 32,
  parameter int TBW = $clog2(LW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [SW-1:0]  cnt0,
  input  logic [SW-1:0]  cnt1,
  input  logic [LW-1:0]  cnt2,
  input  logic [2:0]     stat_raw,
  output cfg_t           cfg,
  output logic [SW-1:0]  m0,
  output logic [SW-1:0]  m1,
  output logic [TBW-1:0] tbit,
  output logic [2:0]     stat_clr,
  output logic [2:0]     crst,
  output logic [DW-1:0]  rdata
);
  lk_t        lk;
  logic       cfg_we;
  logic [2:0] en_q;
  logic [2:0] mask_q;
  logic [1:0] a0_q, a1_q, a2_q;
  logic       clr0_q, clr1_q, c01_q, c12_q;

  logic hit_lock, hit_ctrl, hit_m0, hit_m1, hit_mode, hit_mask, hit_stat, hit_crst;
  assign hit_lock = (addr == AW'(A_LOCK));
  assign hit_ctrl = (addr == AW'(A_CTRL));
  assign hit_m0   = (addr == AW'(A_MATCH0));
  assign hit_m1   = (addr == AW'(A_MATCH1));
  assign hit_mode = (addr == AW'(A_MODE));
  assign hit_mask = (addr == AW'(A_MASK));
  assign hit_stat = (addr == AW'(A_STAT));
  assign hit_crst = (addr == AW'(A_CRST));

  assign cfg_we   = wr & (lk == LK_OPEN) & ~hit_lock;
  assign stat_clr = (wr && hit_stat) ? wdata[2:0] : 3'b000;
  assign crst     = (cfg_we && hit_crst) ? wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk     <= LK_SHUT;
      en_q   <= '0;
      mask_q <= '0;
      a0_q   <= '0;
      a1_q   <= '0;
      a2_q   <= '0;
      clr0_q <= 1'b0;
      clr1_q <= 1'b0;
      c01_q  <= 1'b0;
      c12_q  <= 1'b0;
      tbit   <= '0;
      m0     <= '0;
      m1     <= '0;
    end else begin
      if (wr) begin
        unique case (lk)
          LK_SHUT: if (hit_lock && wdata == DW'(KEY_A)) lk <= LK_HALF;
          LK_HALF: lk <= (hit_lock && wdata == DW'(KEY_B)) ? LK_OPEN : LK_SHUT;
          LK_OPEN: if (hit_lock) lk <= (wdata == DW'(KEY_A)) ? LK_HALF : LK_SHUT;
          default: lk <= LK_SHUT;
        endcase
      end
      if (cfg_we && hit_ctrl) en_q <= wdata[2:0];
      if (cfg_we && hit_m0)   m0   <= wdata[SW-1:0];
      if (cfg_we && hit_m1)   m1   <= wdata[SW-1:0];
      if (cfg_we && hit_mode) begin
        a0_q   <= wdata[1:0];
        a1_q   <= wdata[3:2];
        a2_q   <= wdata[5:4];
        clr0_q <= wdata[8];
        clr1_q <= wdata[9];
        c01_q  <= wdata[12];
        c12_q  <= wdata[13];
        tbit   <= wdata[16 +: TBW];
      end
      if (wr && hit_mask) mask_q <= wdata[2:0];
    end
  end

  always_comb begin
    cfg        = '0;
    cfg.en     = en_q;
    cfg.act0   = act_t'(a0_q);
    cfg.act1   = act_t'(a1_q);
    cfg.act2   = act_t'(a2_q);
    cfg.clr0   = clr0_q;
    cfg.clr1   = clr1_q;
    cfg.casc01 = c01_q;
    cfg.casc12 = c12_q;
    cfg.mask   = mask_q;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_LOCK):   rdata = DW'(lk == LK_OPEN);
      AW'(A_CTRL):   rdata = DW'(en_q);
      AW'(A_MATCH0): rdata = DW'(m0);
      AW'(A_MATCH1): rdata = DW'(m1);
      AW'(A_MODE):   rdata = DW'({tbit, 2'b00, c12_q, c01_q, 2'b00, clr1_q, clr0_q,
                                  2'b00, a2_q, a1_q, a0_q});
      AW'(A_MASK):   rdata = DW'(mask_q);
      AW'(A_STAT):   rdata = DW'({stat_raw, 1'b0, stat_raw & mask_q});
      AW'(A_CNT0):   rdata = DW'(cnt0);
      AW'(A_CNT1):   rdata = DW'(cnt1);
      AW'(A_CNT2):   rdata = DW'(cnt2);
      default:       rdata = '0;
    endcase
  end

  // R2: while not open, an enable write leaves the enables untouched
  p_shut_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_ctrl && lk != LK_OPEN) |=> $stable(en_q));
  // R2: the open state is reached only through the half state
  p_open_via_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lk == LK_OPEN) |-> $past(lk == LK_HALF));
endmodule

// File: rtl/mcw_events.sv
module mcw_events
  import mcw_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  act_t         act [N],
  input  logic [N-1:0] mask,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status,
  output logic         irq,
  output logic         rst_req
);
  logic [N-1:0] armed;
  logic [N-1:0] wdog;

  for (genvar i = 0; i < N; i++) begin : g_act
    assign armed[i] = (act[i] == ACT_IRQ) || (act[i] == ACT_WDOG);
    assign wdog[i]  = (act[i] == ACT_WDOG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      rst_req <= 1'b0;
    end else begin
      status  <= en & ((evt & armed) | (status & ~clr));
      rst_req <= |(evt & wdog & status);
    end
  end

  assign irq = |(status & mask);

  // R7: the reset request never lasts longer than one clock
  p_rst_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7: a reset request needs an already pending status bit
  p_rst_needs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(status) != '0));
  // R10: a counter disabled in one cycle has no status bit in the next
  p_disabled_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(en)) == '0));
  // R6: a status bit rises only from an event of its counter
  p_status_from_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(evt)) == '0));
endmodule

// File: rtl/mcw_top.sv
module mcw_top
  import mcw_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int SW = 16,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          rst_req
);
  localparam int TBW = $clog2(LW);
  localparam int NC  = 3;

  cfg_t           cfg;
  logic [SW-1:0]  m0, m1, cnt0, cnt1;
  logic [LW-1:0]  cnt2;
  logic [TBW-1:0] tbit;
  logic [2:0]     stat_clr, crst, status, evt;
  logic           adv1, adv2;
  act_t           acts [NC];

  assign adv1 = cfg.casc01 ? evt[0] : tick_en;
  assign adv2 = cfg.casc12 ? evt[1] : tick_en;
  assign acts[0] = cfg.act0;
  assign acts[1] = cfg.act1;
  assign acts[2] = cfg.act2;

  mcw_regs #(.AW(AW), .DW(DW), .SW(SW), .LW(LW), .TBW(TBW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cnt0(cnt0), .cnt1(cnt1), .cnt2(cnt2), .stat_raw(status),
    .cfg(cfg), .m0(m0), .m1(m1), .tbit(tbit),
    .stat_clr(stat_clr), .crst(crst), .rdata(reg_rdata)
  );

  mcw_match_ctr #(.W(SW)) u_c0 (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .adv(tick_en), .en(cfg.en[0]),
    .wrap_mode(cfg.clr0), .match(m0), .zap(crst[0]), .cnt(cnt0), .evt(evt[0])
  );

  mcw_match_ctr #(.W(SW)) u_c1 (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .adv(adv1), .en(cfg.en[1]),
    .wrap_mode(cfg.clr1), .match(m1), .zap(crst[1]), .cnt(cnt1), .evt(evt[1])
  );

  mcw_toggle_ctr #(.W(LW), .TBW(TBW)) u_c2 (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .adv(adv2), .en(cfg.en[2]),
    .tbit(tbit), .zap(crst[2]), .cnt(cnt2), .evt(evt[2])
  );

  mcw_events #(.N(NC)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt(evt), .en(cfg.en), .act(acts),
    .mask(cfg.mask), .clr(stat_clr), .status(status), .irq(irq), .rst_req(rst_req)
  );

  // R5: a chained C1 moves only in a cycle where C0 produced an event
  p_casc_c1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.casc01 && !evt[0] && !tick_en) |=> $stable(cnt1));
  // R3: in wrap mode with a nonzero match the short count stays below it
  p_wrap_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.clr0 && m0 != '0 && cnt0 < m0 && $stable(m0)) |=> (cnt0 < m0 || !$stable(m0)));
endmodule

// File: tb/mcw_top_test.sv
`timescale 1ns/1ps
module mcw_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, rst_req;

  int nchk = 0;
  int nerr = 0;
  int rcount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mcw_top uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_req) rcount++;

  // match, wrap, ticks, expected count, expected status bit 0
  localparam int VEC [8][5] = '{
    '{5, 1, 4, 4, 0},
    '{5, 1, 5, 0, 1},
    '{5, 1, 12, 2, 1},
    '{5, 0, 7, 7, 1},
    '{0, 1, 3, 3, 0},
    '{3, 0, 2, 2, 0},
    '{1, 1, 1, 0, 1},
    '{10, 1, 10, 0, 1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(0, 32'hA5);
    wr(0, 32'h5A);
  endtask

  function automatic logic [31:0] mode(input int a0, a1, a2, c0, c1, k01, k12, tb);
    return 32'(a0) | (32'(a1) << 2) | (32'(a2) << 4) | (32'(c0) << 8) |
           (32'(c1) << 9) | (32'(k01) << 12) | (32'(k12) << 13) | (32'(tb) << 16);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(8, v);  chk("R1 cnt0", v, 0);
    rd(9, v);  chk("R1 cnt1", v, 0);
    rd(10, v); chk("R1 cnt2", v, 0);
    rd(6, v);  chk("R1 status", v, 0);
    rd(0, v);  chk("R1 lock", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rst_req", 32'(rst_req), 0);

    // R2 lock behaviour
    wr(2, 32'd7);
    rd(2, v); chk("R2 locked write dropped", v, 0);
    wr(0, 32'hA5);
    wr(2, 32'd7);
    rd(2, v); chk("R2 half-key write dropped", v, 0);
    rd(0, v); chk("R2 relocked after bad second write", v, 0);
    unlock();
    rd(0, v); chk("R2 unlocked", v, 1);
    wr(2, 32'd7);
    rd(2, v); chk("R2 open write taken", v, 7);
    wr(0, 32'h0);
    rd(0, v); chk("R2 relock by lock write", v, 0);
    wr(2, 32'd9);
    rd(2, v); chk("R2 relocked write dropped", v, 7);
    unlock();

    // R3 table of match/wrap cases on C0
    for (int i = 0; i < 8; i++) begin
      wr(1, 0);
      wr(2, 32'(VEC[i][0]));
      wr(4, mode(1, 0, 0, VEC[i][1], 0, 0, 0, 0));
      wr(5, 1);
      wr(7, 1);
      ticks(1);
      wr(1, 1);
      ticks(VEC[i][2]);
      rd(8, v); chk($sformatf("R3 vec%0d count", i), v, 32'(VEC[i][3]));
      rd(6, v); chk($sformatf("R3 vec%0d status", i), v & 1, 32'(VEC[i][4]));
    end

    // R10 no count without tick
    rd(8, v);
    idle(6);
    begin
      logic [31:0] w;
      rd(8, w); chk("R10 frozen without tick", w, v);
    end

    // R11 counter reset request
    wr(1, 0); wr(2, 100); wr(4, mode(1, 0, 0, 1, 0, 0, 0, 0));
    wr(7, 1); ticks(1); wr(1, 1);
    ticks(3);
    wr(7, 1);
    ticks(1);
    rd(8, v); chk("R11 zeroed on tick", v, 0);
    ticks(1);
    rd(8, v); chk("R11 counts after zero", v, 1);

    // R5 and R6 C0 -> C1 cascade, C0 action none
    wr(1, 0); wr(2, 3); wr(3, 2);
    wr(4, mode(0, 1, 0, 1, 1, 1, 0, 0));
    wr(5, 3); wr(7, 3); ticks(1); wr(1, 3);
    ticks(5);
    rd(9, v); chk("R5 c1 stepped once", v, 1);
    rd(6, v); chk("R5 no c1 event yet", v, 0);
    ticks(1);
    rd(6, v); chk("R5 c1 event after 6 ticks", v, 32'h22);
    rd(8, v); chk("R6 c0 none sets no status, count", v, 0);

    // R5 C1 -> C2 cascade
    wr(1, 0); wr(3, 2);
    wr(4, mode(0, 0, 1, 0, 1, 0, 1, 0));
    wr(5, 4); wr(7, 7); ticks(1); wr(1, 6);
    ticks(1);
    rd(6, v); chk("R5 c2 idle before c1 event", v, 0);
    ticks(1);
    rd(10, v); chk("R5 c2 stepped by c1 event", v, 1);
    rd(6, v); chk("R5 c2 bit0 event", v, 32'h44);

    // R4 toggle bit 2
    wr(1, 0);
    wr(4, mode(0, 0, 1, 0, 0, 0, 0, 2));
    wr(7, 4); ticks(1); wr(1, 4);
    ticks(3);
    rd(6, v); chk("R4 no event before bit rise", v, 0);
    ticks(1);
    rd(6, v); chk("R4 event on bit2 rise", v, 32'h44);
    chk("R8 irq with mask", 32'(irq), 1);
    wr(6, 4);
    ticks(3);
    rd(6, v); chk("R4 no event while bit stays high", v, 0);

    // R10 disable clears status
    ticks(5);
    rd(6, v); chk("R4 second rise at count 12", v, 32'h44);
    wr(1, 0);
    rd(6, v); chk("R10 disable clears status", v, 0);
    rd(10, v); chk("R10 count held when disabled", v, 12);

    // R8 mask gating, R9 write-one-to-clear
    wr(2, 1); wr(3, 1);
    wr(4, mode(1, 1, 0, 1, 1, 0, 0, 0));
    wr(5, 0); wr(1, 3);
    ticks(1);
    rd(6, v); chk("R8 masked zero, raw set", v, 32'h30);
    chk("R8 irq low when masked", 32'(irq), 0);
    wr(5, 2);
    rd(6, v); chk("R8 masked c1 only", v, 32'h32);
    chk("R8 irq via c1", 32'(irq), 1);
    wr(6, 2);
    rd(6, v); chk("R9 single bit cleared", v, 32'h10);
    ticks(1);
    wr(6, 3);
    rd(6, v); chk("R9 two bits cleared", v, 0);

    // R7 watchdog
    wr(1, 0); wr(2, 2);
    wr(4, mode(2, 0, 0, 1, 0, 0, 0, 0));
    wr(5, 1); wr(7, 1); ticks(1); wr(1, 1);
    rcount = 0;
    ticks(2);
    chk("R7 first event irq", 32'(irq), 1);
    chk("R7 no reset on first event", 32'(rcount), 0);
    ticks(2);
    idle(3);
    chk("R7 one reset pulse", 32'(rcount), 1);
    wr(6, 1);
    rcount = 0;
    ticks(2);
    idle(2);
    chk("R7 no reset after service", 32'(rcount), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule